// File: doc/BRIEF.md
# Seven-Level Carrier PWM Gate Generator

This block produces the six gate drives of a single-phase seven-level inverter stage. The stage is an H-bridge with two bidirectional switches fed from a three-capacitor divider. A symmetric triangular carrier runs between zero and a programmable peak C. The magnitude of a signed, sampled sine reference is compared against the carrier three times, once at each of the offsets 0, C and 2C. The number of comparisons the magnitude exceeds gives the level size, from 0 to 3. The sign of the reference gives its polarity.

A decoder turns the signed level into a switch pattern. On the fundamental-rate leg, S4 conducts during positive half-cycles and S2 during negative half-cycles. S1, S3, S5 and S6 switch at the carrier rate. A blanking state machine stands between the decoder and the pins. It has three states: ST_IDLE (all gates off), ST_GAP (all gates off while a dead-time counter runs) and ST_DRIVE (the held pattern is applied). It moves between them as follows:
- ST_IDLE to ST_GAP when the enable is high.
- ST_GAP to ST_DRIVE when the dead-time counter reaches zero.
- ST_DRIVE to ST_GAP when the decoded pattern differs from the held one.
- Any state to ST_IDLE when the enable is low.

Gate vector bit i drives switch S(i+1): bit 0 is S1 and bit 5 is S6.

Top module: `tri7_gate_gen`

## Requirements
- R1: The carrier counts up by one per enabled cycle from 0 to the peak `car_peak`, then down by one to 0, and repeats, so one carrier period is 2·C cycles. If the peak is lowered below the present count, the count is clamped to the new peak on the next cycle.
- R2: The level magnitude is the number of k in {0,1,2} for which |ref| > carrier + k·C. The level is negative when the reference is below zero.
- R3: Positive levels drive the following gate vectors: +3 gives S1+S4 (6'b001001), +2 gives S5+S4 (6'b011000), +1 gives S6+S4 (6'b101000).
- R4: Negative levels drive the following gate vectors: −1 gives S5+S2 (6'b010010), −2 gives S6+S2 (6'b100010), −3 gives S2+S3 (6'b000110).
- R5: Level 0 drives S3+S4 (6'b001100) when the reference is zero or positive, and S1+S2 (6'b000011) when it is negative.
- R6: When the decoded pattern differs from the one being driven, all gates go low for `dead_cyc`+1 cycles. After that, the pattern decoded in the last gap cycle is applied.
- R7: While reset is asserted, or in the cycle after the enable is sampled low, all gates are low. Raising the enable first passes through a full blanking gap. The carrier restarts from 0 going up.
- R8: At most two gates are high at once. S2 and S4 are never high together. The gates never step directly from one nonzero pattern to a different nonzero pattern.
- R9: With |ref| ≤ C only levels −1, 0 and +1 occur. With |ref| ≤ 2·C only levels −2 to +2 occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Modulator enable |
| ref_smp | input | REF_W | Signed sine reference sample |
| car_peak | input | CNT_W | Carrier peak C |
| dead_cyc | input | BLK_W | Extra blanking cycles per pattern change |
| gate_out | output | 6 | Gate drives, bit i is switch S(i+1) |

## Verification
A carrier that drifts from its triangle shows up at the pins within one carrier period, as pulse edges out of place against a constant reference. A wrong level threshold or polarity decode produces a wrong gate vector in the first cycle after the following gap. A miscounted dead-time counter lengthens or shortens the all-off window at the very next pattern change. A state machine stuck in ST_GAP or ST_DRIVE is visible one cycle after the enable falls, or as a direct nonzero-to-nonzero gate step.

// File: rtl/tri7_pkg.sv
package tri7_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GAP   = 2'd1,
        ST_DRIVE = 2'd2
    } gate_st_e;

    localparam int NUM_SW = 6;

    // bit i of a pattern drives switch S(i+1)
    localparam logic [NUM_SW-1:0] PAT_P3 = 6'b001001;
    localparam logic [NUM_SW-1:0] PAT_P2 = 6'b011000;
    localparam logic [NUM_SW-1:0] PAT_P1 = 6'b101000;
    localparam logic [NUM_SW-1:0] PAT_ZP = 6'b001100;
    localparam logic [NUM_SW-1:0] PAT_ZN = 6'b000011;
    localparam logic [NUM_SW-1:0] PAT_N1 = 6'b010010;
    localparam logic [NUM_SW-1:0] PAT_N2 = 6'b100010;
    localparam logic [NUM_SW-1:0] PAT_N3 = 6'b000110;

endpackage

// File: rtl/tri7_carrier.sv
module tri7_carrier #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] peak,
    output logic [CNT_W-1:0] cnt
);
    localparam int EXT_W = CNT_W + 1;

    logic             rising;
    logic [EXT_W-1:0] cnt_inc;

    always_comb cnt_inc = EXT_W'(cnt) + EXT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt    <= '0;
            rising <= 1'b1;
        end else if (rising) begin
            if (cnt_inc >= EXT_W'(peak)) begin
                cnt    <= peak;
                rising <= 1'b0;
            end else begin
                cnt <= cnt_inc[CNT_W-1:0];
            end
        end else begin
            if (cnt > peak) begin
                cnt <= peak;
            end else if (cnt <= CNT_W'(1)) begin
                cnt    <= '0;
                rising <= 1'b1;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= $past(peak));

endmodule

// File: rtl/tri7_level.sv
module tri7_level #(
    parameter int REF_W = 12,
    parameter int CNT_W = 8
) (
    input  logic signed [REF_W-1:0] ref_smp,
    input  logic        [CNT_W-1:0] cnt,
    input  logic        [CNT_W-1:0] peak,
    output logic        [1:0]       lvl_mag,
    output logic                    lvl_neg
);
    localparam int BASE_W = (REF_W > CNT_W + 2) ? REF_W : CNT_W + 2;
    localparam int SUM_W  = BASE_W + 1;
    localparam int N_REF  = 3;

    logic [SUM_W-1:0] ref_ext;
    logic [SUM_W-1:0] mag;
    logic [N_REF-1:0] hit;

    always_comb begin
        lvl_neg = ref_smp[REF_W-1];
        ref_ext = {{(SUM_W-REF_W){ref_smp[REF_W-1]}}, ref_smp};
        mag     = lvl_neg ? (~ref_ext + SUM_W'(1)) : ref_ext;
    end

    for (genvar k = 0; k < N_REF; k++) begin : g_cmp
        logic [SUM_W-1:0] thr;
        always_comb begin
            thr    = SUM_W'(cnt) + SUM_W'(peak) * SUM_W'(k);
            hit[k] = mag > thr;
        end
    end

    always_comb lvl_mag = 2'(hit[0]) + 2'(hit[1]) + 2'(hit[2]);

endmodule

// File: rtl/tri7_decode.sv
module tri7_decode
    import tri7_pkg::*;
(
    input  logic [1:0]        lvl_mag,
    input  logic              lvl_neg,
    output logic [NUM_SW-1:0] pat
);
    always_comb begin
        unique case ({lvl_neg, lvl_mag})
            3'b011:  pat = PAT_P3;
            3'b010:  pat = PAT_P2;
            3'b001:  pat = PAT_P1;
            3'b000:  pat = PAT_ZP;
            3'b100:  pat = PAT_ZN;
            3'b101:  pat = PAT_N1;
            3'b110:  pat = PAT_N2;
            default: pat = PAT_N3;
        endcase
    end
endmodule

// File: rtl/tri7_blank_fsm.sv
module tri7_blank_fsm
    import tri7_pkg::*;
#(
    parameter int BLK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [NUM_SW-1:0] want,
    input  logic [BLK_W-1:0]  dead_cyc,
    output logic [NUM_SW-1:0] gate_out
);
    gate_st_e          st_q, st_d;
    logic [BLK_W-1:0]  bcnt_q, bcnt_d;
    logic [NUM_SW-1:0] held_q, held_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            bcnt_q <= '0;
            held_q <= '0;
        end else begin
            st_q   <= st_d;
            bcnt_q <= bcnt_d;
            held_q <= held_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        bcnt_d = bcnt_q;
        held_d = held_q;
        if (!en) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d   = ST_GAP;
                    bcnt_d = dead_cyc;
                end
                ST_GAP: begin
                    if (bcnt_q == '0) begin
                        st_d   = ST_DRIVE;
                        held_d = want;
                    end else begin
                        bcnt_d = bcnt_q - BLK_W'(1);
                    end
                end
                ST_DRIVE: begin
                    if (want != held_q) begin
                        st_d   = ST_GAP;
                        bcnt_d = dead_cyc;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_comb gate_out = (st_q == ST_DRIVE) ? held_q : '0;

    // R7
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> gate_out == '0);
    // R8
    gate_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_out == '0 || $countones(gate_out) == 2);
    // R8
    leg_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_out[1] && gate_out[3]));
    // R6
    no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_out != '0 && $past(gate_out) != '0) |-> gate_out == $past(gate_out));

endmodule

// File: rtl/tri7_gate_gen.sv
module tri7_gate_gen
    import tri7_pkg::*;
#(
    parameter int REF_W = 12,
    parameter int CNT_W = 8,
    parameter int BLK_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [REF_W-1:0] ref_smp,
    input  logic        [CNT_W-1:0] car_peak,
    input  logic        [BLK_W-1:0] dead_cyc,
    output logic        [5:0]       gate_out
);
    logic [CNT_W-1:0]  car_cnt;
    logic [1:0]        lvl_mag;
    logic              lvl_neg;
    logic [NUM_SW-1:0] want_pat;

    tri7_carrier #(.CNT_W(CNT_W)) u_car (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .peak  (car_peak),
        .cnt   (car_cnt)
    );

    tri7_level #(.REF_W(REF_W), .CNT_W(CNT_W)) u_lvl (
        .ref_smp (ref_smp),
        .cnt     (car_cnt),
        .peak    (car_peak),
        .lvl_mag (lvl_mag),
        .lvl_neg (lvl_neg)
    );

    tri7_decode u_dec (
        .lvl_mag (lvl_mag),
        .lvl_neg (lvl_neg),
        .pat     (want_pat)
    );

    tri7_blank_fsm #(.BLK_W(BLK_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .want     (want_pat),
        .dead_cyc (dead_cyc),
        .gate_out (gate_out)
    );

endmodule

// File: tb/test_tri7_gate_gen.sv
module test_tri7_gate_gen;
    localparam int CLK_P = 10;
    localparam int REF_W = 12;
    localparam int CNT_W = 8;
    localparam int BLK_W = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    en = 1'b0;
    logic signed [REF_W-1:0] ref_smp = '0;
    logic        [CNT_W-1:0] car_peak = '0;
    logic        [BLK_W-1:0] dead_cyc = '0;
    logic        [5:0]       gate_out;

    int n_run = 0;
    int n_fail = 0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    // model state
    int         m_cnt = 0;
    bit         m_up = 1'b1;
    int         m_st = 0;
    int         m_bc = 0;
    logic [5:0] m_held = '0;

    always #(CLK_P/2) clk = ~clk;

    tri7_gate_gen #(.REF_W(REF_W), .CNT_W(CNT_W), .BLK_W(BLK_W)) i_tri7_gate_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .ref_smp  (ref_smp),
        .car_peak (car_peak),
        .dead_cyc (dead_cyc),
        .gate_out (gate_out)
    );

    function automatic logic [5:0] pat_of(input int r, input int c, input int p);
        int mag;
        int n;
        mag = (r < 0) ? -r : r;
        n = 0;
        for (int k = 0; k < 3; k++) if (mag > c + k * p) n++;
        if (r < 0) begin
            case (n)
                0: return 6'b000011;
                1: return 6'b010010;
                2: return 6'b100010;
                default: return 6'b000110;
            endcase
        end
        case (n)
            0: return 6'b001100;
            1: return 6'b101000;
            2: return 6'b011000;
            default: return 6'b001001;
        endcase
    endfunction

    task automatic step(input bit e, input int r, input int p, input int b, input string tag);
        logic [5:0] want;
        logic [5:0] outv;
        string      itag;
        @(negedge clk);
        en = e; ref_smp = REF_W'(r); car_peak = CNT_W'(p); dead_cyc = BLK_W'(b);
        want = pat_of(r, m_cnt, p);
        if (!e) begin
            m_cnt = 0; m_up = 1'b1; m_st = 0;
        end else begin
            case (m_st)
                0: begin m_st = 1; m_bc = b; end
                1: if (m_bc == 0) begin m_st = 2; m_held = want; end else m_bc--;
                default: if (want != m_held) begin m_st = 1; m_bc = b; end
            endcase
            if (m_up) begin
                if (m_cnt + 1 >= p) begin m_cnt = p; m_up = 1'b0; end else m_cnt++;
            end else begin
                if (m_cnt > p) m_cnt = p;
                else if (m_cnt <= 1) begin m_cnt = 0; m_up = 1'b1; end
                else m_cnt--;
            end
        end
        outv = (m_st == 2) ? m_held : 6'b0;
        if (m_st == 0) itag = "R7";
        else if (m_st == 1) itag = "R6";
        else if (m_held == 6'b001100 || m_held == 6'b000011) itag = "R5";
        else if (m_held[1]) itag = "R4";
        else itag = "R3";
        @(posedge clk);
        exp_q.push_back(outv);
        tag_q.push_back({tag, "/", itag});
    endtask

    // monitor: pops one expected item per cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [5:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_run++;
                if (gate_out !== e) begin
                    n_fail++;
                    $display("FAIL %s gate_out=%b expected=%b", t, gate_out, e);
                end
                n_run++;
                if ($countones(gate_out) > 2 || (gate_out[1] && gate_out[3])) begin
                    n_fail++;
                    $display("FAIL R8 gate_out=%b expected at most a legal pair", gate_out);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        n_run++;
        if (gate_out !== 6'b0) begin
            n_fail++;
            $display("FAIL R7 reset gate_out=%b expected=000000", gate_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R5 zero reference, positive polarity
        for (int i = 0; i < 40; i++) step(1'b1, 0, 10, 2, "R5");
        // R3 full positive level
        for (int i = 0; i < 40; i++) step(1'b1, 35, 10, 2, "R3");
        // R4 full negative level
        for (int i = 0; i < 40; i++) step(1'b1, -35, 10, 2, "R4");
        // R2 mid band, between C and 2C
        for (int i = 0; i < 60; i++) step(1'b1, 17, 10, 1, "R2");
        // R9 small negative reference: three-level operation
        for (int i = 0; i < 60; i++) step(1'b1, -7, 10, 0, "R9");
        // R9 five-level band
        for (int i = 0; i < 60; i++) step(1'b1, -18, 10, 1, "R9");
        // R2 sine sweep, seven levels
        for (int i = 0; i < 400; i++)
            step(1'b1, $rtoi(28.0 * $sin(6.2831853 * i / 200.0)), 10, 1, "R2");
        // R6 no extra dead time
        for (int i = 0; i < 200; i++)
            step(1'b1, $rtoi(25.0 * $sin(6.2831853 * i / 200.0)), 10, 0, "R6");
        // R1 peak lowered mid-run, then raised
        for (int i = 0; i < 60; i++) step(1'b1, 9, 12, 1, "R1");
        for (int i = 0; i < 60; i++) step(1'b1, 9, 4, 1, "R1");
        for (int i = 0; i < 60; i++) step(1'b1, 9, 7, 3, "R1");
        // R7 disable mid-run, then restart
        for (int i = 0; i < 5; i++) step(1'b0, 20, 10, 3, "R7");
        for (int i = 0; i < 40; i++) step(1'b1, 20, 10, 3, "R7");
        // R5 tiny negative reference, zero via S1+S2
        for (int i = 0; i < 40; i++) step(1'b1, -1, 10, 0, "R5");
        step(1'b0, 0, 10, 0, "R7");
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule